// File: doc/BRIEF.md
# Predicated Vector Element Adder

This block walks through a vector of 64-bit integer elements held in an external register file. At each step it reads one element from each of two source vectors, adds them with a carry, and writes the sum to a destination vector. Each element group has its own 4-bit condition field in an external condition file. The carry into a group is taken from the summary-overflow bit of that group's field, and the carry out of the group is written back into the same bit. No single shared carry or overflow flag exists, so independent groups never contend for one status bit.

A launch takes a vector length, a sub-vector size of 1 to 4, an optional predicate mask and base indices for the two sources, the destination and the condition fields. With a sub-vector size above one, each group of lanes shares one predicate bit and one condition field. The carry then ripples through the lanes of the group. The lanes' sign and zero tests are merged into the field by a bitwise OR or AND, picked by a mode input. The unit is busy from one cycle after launch until the cycle before a single-cycle done pulse. It exposes the index of the group being worked on as saved context.

Top module: `vec_pred_adder`

## Requirements
- R1: After reset, busy_o, done_o, rf_we_o and cr_we_o are all low. Neither write enable is ever high while busy_o is low.
- R2: For a live lane at element position e (counted from 0 over all lanes), the word written to destination index rd_base_i+e is rf[ra_base_i+e] + rf[rb_base_i+e] + carry-in, modulo 2^64. Indices wrap at the register-file size. The carry-in of the first lane of group g is bit 0 of condition field cr_base_i+g. Later lanes take the carry-out of the previous lane.
- R3: When a live group finishes, condition field cr_base_i+g receives, in bit 0, the carry-out of its last lane. Bit 3 is less-than, bit 2 greater-than and bit 1 equal, each from the signed comparison of the result with zero.
- R4: Groups are processed in ascending index order and live lanes in ascending element order, one live lane per cycle. srcoffs_o shows the current group index on each write.
- R5: With pred_en_i low the mask is treated as all ones, and every lane of every group is written.
- R6: A group whose predicate bit pred_mask_i[g] is 0 costs exactly one cycle. It writes neither its destination words nor its condition field.
- R7: subvl_i encodes the group size minus one (0 gives 1 lane, 3 gives 4 lanes). Each group uses one predicate bit and one condition field.
- R8: Within a group, the less-than, greater-than and equal bits written are the bitwise OR of the lane tests when merge_and_i is 0, and the bitwise AND when it is 1.
- R9: A launch with vl_i equal to 0 raises done_o in the next cycle, performs no writes and never raises busy_o.
- R10: start_i is ignored while busy_o is high. The running operation, its inputs and its results are unaffected.
- R11: done_o is a one-cycle pulse in the cycle right after the last write. busy_o is low by then.
- R12: A vl_i above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request, taken only while idle |
| vl_i | input | 7 | Number of groups |
| subvl_i | input | 2 | Lanes per group minus one |
| pred_en_i | input | 1 | Use pred_mask_i when high |
| pred_mask_i | input | 64 | One enable bit per group |
| merge_and_i | input | 1 | 1: AND lane tests, 0: OR them |
| rd_base_i | input | 8 | Destination start index |
| ra_base_i | input | 8 | First source start index |
| rb_base_i | input | 8 | Second source start index |
| cr_base_i | input | 6 | First condition field index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| srcoffs_o | output | 6 | Current group index |
| rf_ra_addr_o | output | 8 | First source read index |
| rf_ra_data_i | input | 64 | First source read data, same cycle |
| rf_rb_addr_o | output | 8 | Second source read index |
| rf_rb_data_i | input | 64 | Second source read data, same cycle |
| rf_we_o | output | 1 | Destination write enable |
| rf_wa_o | output | 8 | Destination write index |
| rf_wd_o | output | 64 | Destination write data |
| cr_rd_addr_o | output | 6 | Condition field read index |
| cr_so_i | input | 1 | Summary-overflow bit of that field |
| cr_we_o | output | 1 | Condition field write enable |
| cr_wa_o | output | 6 | Condition field write index |
| cr_wd_o | output | 4 | Condition field write data |

## Verification
The bench goes after carry traffic. It presets summary-overflow bits and picks operands whose sums wrap to zero, so a design that used a shared carry, or did not write the carry back, leaves wrong words and fields behind. Masked groups are checked for untouched words and fields and a one-cycle cost. Zero-length and over-length launches would show up as stray writes, a missing pulse or a wrong write count. Mixed-sign lanes in groups of two and three show whether the OR/AND merge is wrong or the intra-group carry chain is broken. A start pulse in mid-run with a changed destination would corrupt results in a design that accepted it.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    // largest group size handled by the sequencer
    localparam int SUB_MAX = 4;

    // condition field bit positions
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vpa_state_e;

    // sign and zero tests of one lane result
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } vpa_test_t;

endpackage

// File: rtl/vpa_elem_alu.sv
module vpa_elem_alu
    import vpa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            cin_i,
    output logic [XLEN-1:0] sum_o,
    output logic            cout_o,
    output vpa_test_t       test_o
);

    logic [XLEN:0] wide;

    assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};
    assign sum_o  = wide[XLEN-1:0];
    assign cout_o = wide[XLEN];

    always_comb begin
        test_o.lt = sum_o[XLEN-1];
        test_o.eq = (sum_o == '0);
        test_o.gt = !sum_o[XLEN-1] && (sum_o != '0);
    end

endmodule

// File: rtl/vpa_cond_merge.sv
module vpa_cond_merge
    import vpa_pkg::*;
(
    input  vpa_test_t acc_i,
    input  vpa_test_t lane_i,
    input  logic      first_i,
    input  logic      and_mode_i,
    output vpa_test_t merged_o
);

    always_comb begin
        if (first_i) begin
            merged_o = lane_i;
        end else if (and_mode_i) begin
            merged_o = vpa_test_t'(acc_i & lane_i);
        end else begin
            merged_o = vpa_test_t'(acc_i | lane_i);
        end
    end

endmodule

// File: rtl/vpa_pred_sel.sv
module vpa_pred_sel #(
    parameter  int MAX_VL = 64,
    localparam int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              pred_en_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              live_o
);

    logic [MAX_VL-1:0] eff;

    for (genvar g = 0; g < MAX_VL; g++) begin : g_bit
        assign eff[g] = mask_i[g] | ~pred_en_i;
    end

    assign live_o = eff[idx_i];

endmodule

// File: rtl/vec_pred_adder.sv
module vec_pred_adder
    import vpa_pkg::*;
#(
    parameter  int XLEN   = 64,
    parameter  int MAX_VL = 64,
    parameter  int REG_AW = 8,
    parameter  int CR_AW  = 6,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int IDX_W  = $clog2(MAX_VL),
    localparam int ELEM_W = $clog2(MAX_VL * SUB_MAX),
    localparam int CF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [1:0]        subvl_i,
    input  logic              pred_en_i,
    input  logic [MAX_VL-1:0] pred_mask_i,
    input  logic              merge_and_i,
    input  logic [REG_AW-1:0] rd_base_i,
    input  logic [REG_AW-1:0] ra_base_i,
    input  logic [REG_AW-1:0] rb_base_i,
    input  logic [CR_AW-1:0]  cr_base_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  srcoffs_o,
    output logic [REG_AW-1:0] rf_ra_addr_o,
    input  logic [XLEN-1:0]   rf_ra_data_i,
    output logic [REG_AW-1:0] rf_rb_addr_o,
    input  logic [XLEN-1:0]   rf_rb_data_i,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_wa_o,
    output logic [XLEN-1:0]   rf_wd_o,
    output logic [CR_AW-1:0]  cr_rd_addr_o,
    input  logic              cr_so_i,
    output logic              cr_we_o,
    output logic [CR_AW-1:0]  cr_wa_o,
    output logic [CF_W-1:0]   cr_wd_o
);

    typedef struct packed {
        vpa_state_e        st;
        logic [VL_W-1:0]   vl;
        logic [1:0]        subm1;
        logic              pred_en;
        logic [MAX_VL-1:0] mask;
        logic              and_mode;
        logic [REG_AW-1:0] rd_base;
        logic [REG_AW-1:0] ra_base;
        logic [REG_AW-1:0] rb_base;
        logic [CR_AW-1:0]  cr_base;
        logic [IDX_W-1:0]  sv;
        logic [1:0]        lane;
        logic [ELEM_W-1:0] elem;
        logic              carry;
        vpa_test_t         acc;
        logic              done;
    } ctl_t;

    ctl_t q_q, q_d;

    logic [VL_W-1:0] vl_eff;
    logic            elem_live;
    logic            lane_first;
    logic            lane_last;
    logic            sv_last;
    logic            lane_cin;
    logic [XLEN-1:0] lane_sum;
    logic            lane_cout;
    vpa_test_t       lane_test;
    vpa_test_t       merged;

    // lengths above the limit are treated as the limit
    assign vl_eff = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;

    assign lane_first = (q_q.lane == 2'd0);
    assign lane_last  = (q_q.lane == q_q.subm1);
    assign sv_last    = ((VL_W'(q_q.sv) + VL_W'(1)) == q_q.vl);
    assign lane_cin   = lane_first ? cr_so_i : q_q.carry;

    vpa_pred_sel #(
        .MAX_VL (MAX_VL)
    ) u_pred (
        .pred_en_i (q_q.pred_en),
        .mask_i    (q_q.mask),
        .idx_i     (q_q.sv),
        .live_o    (elem_live)
    );

    vpa_elem_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .a_i    (rf_ra_data_i),
        .b_i    (rf_rb_data_i),
        .cin_i  (lane_cin),
        .sum_o  (lane_sum),
        .cout_o (lane_cout),
        .test_o (lane_test)
    );

    vpa_cond_merge u_merge (
        .acc_i      (q_q.acc),
        .lane_i     (lane_test),
        .first_i    (lane_first),
        .and_mode_i (q_q.and_mode),
        .merged_o   (merged)
    );

    // address generation from the running element and group counters
    assign rf_ra_addr_o = q_q.ra_base + REG_AW'(q_q.elem);
    assign rf_rb_addr_o = q_q.rb_base + REG_AW'(q_q.elem);
    assign rf_wa_o      = q_q.rd_base + REG_AW'(q_q.elem);
    assign rf_wd_o      = lane_sum;
    assign cr_rd_addr_o = q_q.cr_base + CR_AW'(q_q.sv);
    assign cr_wa_o      = cr_rd_addr_o;
    assign cr_wd_o      = {merged.lt, merged.gt, merged.eq, lane_cout};

    assign busy_o    = (q_q.st == ST_RUN);
    assign done_o    = q_q.done;
    assign srcoffs_o = q_q.sv;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        rf_we_o  = 1'b0;
        cr_we_o  = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    q_d.vl       = vl_eff;
                    q_d.subm1    = subvl_i;
                    q_d.pred_en  = pred_en_i;
                    q_d.mask     = pred_mask_i;
                    q_d.and_mode = merge_and_i;
                    q_d.rd_base  = rd_base_i;
                    q_d.ra_base  = ra_base_i;
                    q_d.rb_base  = rb_base_i;
                    q_d.cr_base  = cr_base_i;
                    q_d.sv       = '0;
                    q_d.lane     = '0;
                    q_d.elem     = '0;
                    q_d.carry    = 1'b0;
                    q_d.acc      = '0;
                    if (vl_eff == '0) begin
                        q_d.done = 1'b1;
                    end else begin
                        q_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!elem_live) begin
                    // whole group skipped in a single step
                    q_d.elem = q_q.elem + ELEM_W'(q_q.subm1) + ELEM_W'(1);
                    q_d.lane = '0;
                    q_d.sv   = q_q.sv + IDX_W'(1);
                    if (sv_last) begin
                        q_d.st   = ST_IDLE;
                        q_d.done = 1'b1;
                    end
                end else begin
                    rf_we_o   = 1'b1;
                    q_d.carry = lane_cout;
                    q_d.acc   = merged;
                    q_d.elem  = q_q.elem + ELEM_W'(1);
                    if (lane_last) begin
                        cr_we_o  = 1'b1;
                        q_d.lane = '0;
                        q_d.sv   = q_q.sv + IDX_W'(1);
                        if (sv_last) begin
                            q_d.st   = ST_IDLE;
                            q_d.done = 1'b1;
                        end
                    end else begin
                        q_d.lane = q_q.lane + 2'd1;
                    end
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/vpa_checker.sv
module vpa_checker #(
    parameter int VL_W  = 7,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [VL_W-1:0]  vl_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             rf_we_o,
    input logic             cr_we_o,
    input logic [IDX_W-1:0] srcoffs_o,
    input logic             live_i
);

    // R1: no write while idle
    a_r1_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || cr_we_o) |-> busy_o);

    // R6: a masked group never writes
    a_r6_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> live_i);

    // R7: a field write closes a lane write of the same group
    a_r7_field_with_lane: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we_o |-> rf_we_o);

    // R4: group index never goes backwards within one run
    a_r4_index_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (srcoffs_o >= $past(srcoffs_o)));

    // R9: empty launch completes next cycle without going busy
    a_r9_empty_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o && (vl_i == '0)) |=> (done_o && !busy_o));

    // R10: a start during a run does not restart or stall it
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R11: single-cycle completion pulse while idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind vec_pred_adder vpa_checker #(
    .VL_W  (VL_W),
    .IDX_W (IDX_W)
) u_vpa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rf_we_o   (rf_we_o),
    .cr_we_o   (cr_we_o),
    .srcoffs_o (srcoffs_o),
    .live_i    (elem_live)
);

// File: tb/vec_pred_adder_tb_top.sv
module vec_pred_adder_tb_top;

    localparam int NREG = 256;
    localparam int NCR  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  subvl_i = '0;
    logic        pred_en_i = 1'b0;
    logic [63:0] pred_mask_i = '0;
    logic        merge_and_i = 1'b0;
    logic [7:0]  rd_base_i = '0;
    logic [7:0]  ra_base_i = '0;
    logic [7:0]  rb_base_i = '0;
    logic [5:0]  cr_base_i = '0;
    logic        busy_o, done_o;
    logic [5:0]  srcoffs_o;
    logic [7:0]  rf_ra_addr_o, rf_rb_addr_o, rf_wa_o;
    logic [63:0] rf_ra_data_i, rf_rb_data_i, rf_wd_o;
    logic        rf_we_o, cr_we_o, cr_so_i;
    logic [5:0]  cr_rd_addr_o, cr_wa_o;
    logic [3:0]  cr_wd_o;

    logic [63:0] rf [NREG];
    logic [3:0]  cr [NCR];
    logic [63:0] exp_rf [NREG];
    logic [3:0]  exp_cr [NCR];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vec_pred_adder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
        .pred_en_i(pred_en_i), .pred_mask_i(pred_mask_i), .merge_and_i(merge_and_i),
        .rd_base_i(rd_base_i), .ra_base_i(ra_base_i), .rb_base_i(rb_base_i),
        .cr_base_i(cr_base_i), .busy_o(busy_o), .done_o(done_o), .srcoffs_o(srcoffs_o),
        .rf_ra_addr_o(rf_ra_addr_o), .rf_ra_data_i(rf_ra_data_i),
        .rf_rb_addr_o(rf_rb_addr_o), .rf_rb_data_i(rf_rb_data_i),
        .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o),
        .cr_rd_addr_o(cr_rd_addr_o), .cr_so_i(cr_so_i), .cr_we_o(cr_we_o),
        .cr_wa_o(cr_wa_o), .cr_wd_o(cr_wd_o)
    );

    // external storage models
    assign rf_ra_data_i = rf[rf_ra_addr_o];
    assign rf_rb_data_i = rf[rf_rb_addr_o];
    assign cr_so_i      = cr[cr_rd_addr_o][0];

    always @(posedge clk) begin
        if (rf_we_o) rf[rf_wa_o] <= rf_wd_o;
        if (cr_we_o) cr[cr_wa_o] <= cr_wd_o;
    end

    // observation away from the active edge
    int neg_cnt = 0;
    int wr_cnt = 0;
    int last_wr_neg = -1;
    int done_cnt = 0;
    int done_neg = -1;
    int busy_cnt = 0;
    int log_idx [512];
    int log_addr [512];

    always @(negedge clk) begin
        neg_cnt = neg_cnt + 1;
        if (rf_we_o) begin
            log_idx[wr_cnt]  = int'(srcoffs_o);
            log_addr[wr_cnt] = int'(rf_wa_o);
            wr_cnt = wr_cnt + 1;
            last_wr_neg = neg_cnt;
        end
        if (busy_o) busy_cnt = busy_cnt + 1;
        if (done_o) begin
            if (done_cnt == 0) done_neg = neg_cnt;
            done_cnt = done_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_rf();
        for (int k = 0; k < NREG; k++) begin
            rf[k] = (64'h0123_4567_89AB_CDEF * 64'(k + 1)) ^ (64'(k) << 40);
        end
        for (int k = 0; k < NCR; k++) begin
            cr[k] = 4'(k * 5);
        end
    endtask

    // reference model written from the requirements
    task automatic model(input int vl, input int sub, input bit pen, input logic [63:0] mask,
                         input bit andm, input int rd, input int ra, input int rb, input int cb,
                         output int steps, output int writes);
        int veff;
        int elem;
        logic c;
        logic [64:0] s65;
        logic [63:0] s;
        logic [2:0] tf, acc;
        for (int k = 0; k < NREG; k++) exp_rf[k] = rf[k];
        for (int k = 0; k < NCR; k++) exp_cr[k] = cr[k];
        veff = (vl > 64) ? 64 : vl;
        elem = 0;
        steps = 0;
        writes = 0;
        acc = '0;
        for (int g = 0; g < veff; g++) begin
            if (!pen || mask[g]) begin
                c = exp_cr[(cb + g) % NCR][0];
                for (int j = 0; j < sub; j++) begin
                    s65 = {1'b0, exp_rf[(ra + elem) % NREG]} + {1'b0, exp_rf[(rb + elem) % NREG]}
                          + 65'(c);
                    s = s65[63:0];
                    c = s65[64];
                    tf = {s[63], (!s[63] && s != 0), (s == 0)};
                    if (j == 0) acc = tf;
                    else if (andm) acc = acc & tf;
                    else acc = acc | tf;
                    exp_rf[(rd + elem) % NREG] = s;
                    elem = elem + 1;
                    steps = steps + 1;
                    writes = writes + 1;
                end
                exp_cr[(cb + g) % NCR] = {acc, c};
            end else begin
                elem = elem + sub;
                steps = steps + 1;
            end
        end
    endtask

    task automatic compare(input string req);
        int bad_rf = 0;
        int bad_cr = 0;
        int first_rf = -1;
        int first_cr = -1;
        for (int k = 0; k < NREG; k++) begin
            if (rf[k] !== exp_rf[k]) begin
                if (first_rf < 0) first_rf = k;
                bad_rf = bad_rf + 1;
            end
        end
        for (int k = 0; k < NCR; k++) begin
            if (cr[k] !== exp_cr[k]) begin
                if (first_cr < 0) first_cr = k;
                bad_cr = bad_cr + 1;
            end
        end
        if (first_rf >= 0) chk(req, $sformatf("reg[%0d]", first_rf), rf[first_rf], exp_rf[first_rf]);
        else chk(req, "register file", 64'd0, 64'd0);
        if (first_cr >= 0) chk(req, $sformatf("field[%0d]", first_cr), 64'(cr[first_cr]), 64'(exp_cr[first_cr]));
        else chk(req, "condition file", 64'd0, 64'd0);
    endtask

    // launch one operation and wait for completion; intrude_at>0 pulses start mid-run
    task automatic run_op(input string req, input int vl, input int sub, input bit pen,
                          input logic [63:0] mask, input bit andm, input int rd, input int ra,
                          input int rb, input int cb, input int intrude_at,
                          output int steps, output int writes, output int start_neg);
        int guard;
        model(vl, sub, pen, mask, andm, rd, ra, rb, cb, steps, writes);
        vl_i = 7'(vl);
        subvl_i = 2'(sub - 1);
        pred_en_i = pen;
        pred_mask_i = mask;
        merge_and_i = andm;
        rd_base_i = 8'(rd);
        ra_base_i = 8'(ra);
        rb_base_i = 8'(rb);
        cr_base_i = 6'(cb);
        wr_cnt = 0;
        done_cnt = 0;
        done_neg = -1;
        last_wr_neg = -1;
        busy_cnt = 0;
        start_i = 1'b1;
        start_neg = neg_cnt;
        @(negedge clk); #1;
        start_i = 1'b0;
        guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            if (intrude_at > 0 && guard == intrude_at) begin
                start_i = 1'b1;
                rd_base_i = 8'(rd + 17);
                vl_i = 7'd1;
            end else begin
                start_i = 1'b0;
                rd_base_i = 8'(rd);
                vl_i = 7'(vl);
            end
            @(negedge clk); #1;
            guard = guard + 1;
        end
        start_i = 1'b0;
        rd_base_i = 8'(rd);
        if (done_cnt == 0) chk(req, "completion seen", 64'd0, 64'd1);
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk("R11", "done pulse count", 64'(done_cnt), 64'd1);
        chk("R4", "cycles to done", 64'(done_neg - start_neg), 64'(steps + 1));
        chk(req, "write count", 64'(wr_cnt), 64'(writes));
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", 64'(busy_o), 64'd0);
        chk("R1", "done after reset", 64'(done_o), 64'd0);
        chk("R1", "writes after reset", 64'({rf_we_o, cr_we_o}), 64'd0);
    endtask

    task automatic t_basic();
        int st, wr, sn;
        fill_rf();
        // lane 0: wraps to zero with carry; lane 1: negative; lane 2: zero plus carry-in
        rf[8'h00] = 64'hFFFF_FFFF_FFFF_FFFF; rf[8'h40] = 64'd1;
        rf[8'h01] = 64'h8000_0000_0000_0000; rf[8'h41] = 64'd5;
        rf[8'h02] = 64'd0;                   rf[8'h42] = 64'd0;
        cr[10] = 4'b0000; cr[11] = 4'b0001; cr[12] = 4'b0001;
        run_op("R2", 6, 1, 1'b0, 64'd0, 1'b0, 8'h80, 8'h00, 8'h40, 10, 0, st, wr, sn);
        compare("R3");
        chk("R5", "all lanes written without mask", 64'(wr_cnt), 64'd6);
    endtask

    task automatic t_order();
        int st, wr, sn;
        bit ok;
        fill_rf();
        run_op("R4", 5, 2, 1'b0, 64'd0, 1'b0, 8'h90, 8'h10, 8'h50, 20, 0, st, wr, sn);
        compare("R4");
        ok = 1'b1;
        for (int w = 0; w < 10; w++) begin
            if (log_idx[w] != w / 2 || log_addr[w] != 8'h90 + w) ok = 1'b0;
        end
        chk("R4", "write order and srcoffs", 64'(ok), 64'd1);
        chk("R11", "done right after last write", 64'(done_neg - last_wr_neg), 64'd1);
    endtask

    task automatic t_pred();
        int st, wr, sn;
        fill_rf();
        run_op("R6", 8, 1, 1'b1, 64'b1011_0010, 1'b0, 8'hA0, 8'h20, 8'h60, 30, 0, st, wr, sn);
        compare("R6");
        chk("R6", "masked lanes unwritten", 64'(wr_cnt), 64'd4);
    endtask

    task automatic t_sub_or();
        int st, wr, sn;
        fill_rf();
        // group 0 lane 0 overflows so lane 1 gets the carry
        rf[8'h04] = 64'hFFFF_FFFF_FFFF_FFFF; rf[8'h44] = 64'hFFFF_FFFF_FFFF_FFFF;
        rf[8'h05] = 64'd0;                   rf[8'h45] = 64'd0;
        rf[8'h06] = 64'hFFFF_FFFF_FFFF_FFFF; rf[8'h46] = 64'd0;
        cr[40] = 4'b0001;
        run_op("R7", 3, 3, 1'b1, 64'b101, 1'b0, 8'hB0, 8'h04, 8'h44, 40, 0, st, wr, sn);
        compare("R8");
    endtask

    task automatic t_sub_and();
        int st, wr, sn;
        fill_rf();
        rf[8'h08] = 64'd0; rf[8'h48] = 64'd0;
        rf[8'h09] = 64'd3; rf[8'h49] = 64'd4;
        rf[8'h0A] = 64'd7; rf[8'h4A] = 64'd1;
        rf[8'h0B] = 64'd2; rf[8'h4B] = 64'd2;
        cr[50] = 4'b0000; cr[51] = 4'b0000;
        run_op("R8", 4, 2, 1'b0, 64'd0, 1'b1, 8'hC0, 8'h08, 8'h48, 50, 0, st, wr, sn);
        compare("R8");
    endtask

    task automatic t_vl0();
        int st, wr, sn;
        fill_rf();
        run_op("R9", 0, 1, 1'b0, 64'd0, 1'b0, 8'hD0, 8'h00, 8'h40, 0, 0, st, wr, sn);
        compare("R9");
        chk("R9", "done one cycle after start", 64'(done_neg - sn), 64'd1);
        chk("R9", "busy never raised", 64'(busy_cnt), 64'd0);
    endtask

    task automatic t_busy_start();
        int st, wr, sn;
        fill_rf();
        run_op("R10", 6, 1, 1'b0, 64'd0, 1'b0, 8'hE0, 8'h18, 8'h58, 3, 3, st, wr, sn);
        compare("R10");
    endtask

    task automatic t_clamp();
        int st, wr, sn;
        fill_rf();
        run_op("R12", 100, 1, 1'b0, 64'd0, 1'b0, 8'h80, 8'h00, 8'h40, 0, 0, st, wr, sn);
        compare("R12");
        chk("R12", "write count clamped", 64'(wr_cnt), 64'd64);
    endtask

    initial begin
        fill_rf();
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_basic();
        t_order();
        t_pred();
        t_sub_or();
        t_sub_and();
        t_vl0();
        t_busy_start();
        t_clamp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule